// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion. Software starts a conversion by setting a start/busy bit through a small write port. The sequencer then presents a trial code to an external DAC and comparator, one bit per conversion-clock period with the most significant bit first. It reads the comparator's single-bit answer back and keeps or drops each trial bit. When the last bit has been resolved, one more conversion-clock period stores the code into two 8-bit result registers. The block then clears the busy bit, sets a sticky completion flag and, if interrupts are enabled, drives its interrupt output.

The conversion clock comes from the system clock divided by a power of two. A 3-bit select picks the ratio using a non-sequential encoding, or it picks an externally supplied slow-clock enable instead. Software can stop a running conversion at any time. In that case the result registers keep their previous contents, and no new conversion is accepted until two conversion-clock periods have passed. The result is stored either left-justified or right-justified, and any bit without a result bit reads as zero.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The control register is at address 0, with bit0 = converter on, bit1 = start/busy, bit2 = right-justify and bit3 = interrupt enable. A write there that sets bit0 and bit1, while the converter was already on before that write, starts a conversion. From the next cycle `busy` is 1 and `trial_code` is 0x200.
- R2: A write to address 0 that sets bit1 does not start a conversion in either of two cases: the converter was off before the write (even if the same write switches it on), or the write leaves bit0 clear.
- R3: Each conversion-clock period resolves one bit, from bit 9 down to bit 0. A trial bit is kept when `cmp_in` is 1. One further period stores the result, and `busy` then falls and `done_flag` rises together.
- R4: Clock select is bits [2:0] at address 1. The codes map as follows: 000 divides by 2, 100 by 4, 001 by 8, 101 by 16, 010 by 32 and 110 by 64. Any code with bits [1:0] = 11 advances the conversion only on cycles where `rc_tick` is 1.
- R5: `irq` equals `done_flag` gated by the interrupt-enable bit.
- R6: `done_flag` stays set until software writes 0 to bit0 at address 2. Starting a new conversion does not clear it.
- R7: Writing address 0 with bit1 clear, or with bit0 clear, while `busy` is 1 aborts the conversion. `busy` drops on the next cycle. `res_hi`, `res_lo` and `done_flag` do not change.
- R8: After an abort, start requests are ignored until two conversion-clock periods have elapsed. After that, a start request is accepted normally.
- R9: With right-justify clear, `res_hi` holds result bits 9..2 and `res_lo` holds bits 1..0 in its bits 7..6. Bits 5..0 of `res_lo` read 0.
- R10: With right-justify set, `res_hi` holds result bits 9..8 in its bits 1..0, with bits 7..2 at 0. `res_lo` holds bits 7..0.
- R11: The divider restarts on every start and every abort. With ratio N, `busy` is still 1 exactly 11·N−1 cycles after the start edge and is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 clock select, 2 flag) |
| wr_data | input | 8 | Register write data |
| rc_tick | input | 1 | External slow-clock enable, one cycle per period |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above the trial code |
| trial_code | output | 10 | Code driven to the external DAC |
| busy | output | 1 | Start/busy bit, cleared by hardware at completion |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs. First, the clock select does not change while a conversion or a recovery gap is running. Second, `rc_tick` is a single-cycle pulse. Third, `cmp_in` settles within the same cycle from the current `trial_code`. The bench meets these conditions as follows. It writes the clock select only while the block is idle. It drives `cmp_in` combinationally from a target value compared against `trial_code`. It issues every write, and every external tick, as a one-cycle pulse placed between falling edges.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int RES_W  = 10;
    localparam int REG_W  = 8;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CLK  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

    localparam int CB_EN = 0;
    localparam int CB_GO = 1;
    localparam int CB_RJ = 2;
    localparam int CB_IE = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_LATCH = 2'd2,
        ST_RECOV = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
    parameter int DIV_W = 6,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_tick,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t             q_q, q_d;
    logic             ext_mode;
    logic [2:0]       ratio_idx;
    logic [CW-1:0]    full_lim;
    logic [DIV_W-1:0] lim;
    logic             hit;

    always_comb begin
        ext_mode  = (sel[1:0] == 2'b11);
        ratio_idx = {sel[1:0], sel[2]};
        full_lim  = (CW'(2) << ratio_idx) - CW'(1);
        lim       = full_lim[DIV_W-1:0];
        hit       = (q_q.cnt == lim);
        tick      = ext_mode ? ext_tick : hit;

        q_d = q_q;
        if (clr || !run || ext_mode || hit) begin
            q_d.cnt = '0;
        end else begin
            q_d.cnt = q_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ext_mode) |-> (q_q.cnt <= lim)); // R4
endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
    parameter int RES_W = 10,
    parameter int REG_W = 8
) (
    input  logic [RES_W-1:0] code,
    input  logic             rjust,
    output logic [REG_W-1:0] hi,
    output logic [REG_W-1:0] lo
);
    localparam int PAD = 2 * REG_W - RES_W;

    always_comb begin
        if (rjust) begin
            {hi, lo} = {{PAD{1'b0}}, code};
        end else begin
            hi = code[RES_W-1 -: REG_W];
            lo = {code[RES_W-REG_W-1:0], {PAD{1'b0}}};
        end
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int DIV_W     = 6,
    parameter int REC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rc_tick,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  trial_code,
    output logic              busy,
    output logic [REG_W-1:0]  res_hi,
    output logic [REG_W-1:0]  res_lo,
    output logic              done_flag,
    output logic              irq
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int REC_W = (REC_TICKS > 1) ? $clog2(REC_TICKS) : 1;

    typedef struct packed {
        sar_state_e       st;
        logic             en;
        logic             rj;
        logic             ie;
        logic             flag;
        logic [SEL_W-1:0] sel;
        logic [RES_W-1:0] code;
        logic [IDX_W-1:0] idx;
        logic [REC_W-1:0] rec;
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } ctl_t;

    ctl_t             q_q, q_d;
    logic             tick;
    logic             div_clr;
    logic             run;
    logic             wr_ctrl, wr_clk, wr_flag;
    logic             abort_req, start_req, latch_hit;
    logic [IDX_W-1:0] idx_next;
    logic [REG_W-1:0] fmt_hi, fmt_lo;
    logic             unused_wr;

    assign unused_wr = ^wr_data[REG_W-1:4];
    assign run       = (q_q.st != ST_IDLE);

    sar_tick_gen #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(div_clr),
        .sel(q_q.sel), .ext_tick(rc_tick), .tick(tick)
    );

    sar_fmt #(.RES_W(RES_W), .REG_W(REG_W)) u_fmt (
        .code(q_q.code), .rjust(q_q.rj), .hi(fmt_hi), .lo(fmt_lo)
    );

    always_comb begin
        q_d       = q_q;
        div_clr   = 1'b0;
        idx_next  = q_q.idx - IDX_W'(1);
        wr_ctrl   = wr_en && (wr_addr == A_CTRL);
        wr_clk    = wr_en && (wr_addr == A_CLK);
        wr_flag   = wr_en && (wr_addr == A_FLAG);
        busy      = (q_q.st == ST_CONV) || (q_q.st == ST_LATCH);
        abort_req = wr_ctrl && busy && (!wr_data[CB_GO] || !wr_data[CB_EN]);
        start_req = wr_ctrl && (q_q.st == ST_IDLE) && q_q.en
                    && wr_data[CB_EN] && wr_data[CB_GO];
        latch_hit = 1'b0;

        if (wr_ctrl) begin
            q_d.en = wr_data[CB_EN];
            q_d.rj = wr_data[CB_RJ];
            q_d.ie = wr_data[CB_IE];
        end
        if (wr_clk)  q_d.sel  = wr_data[SEL_W-1:0];
        if (wr_flag) q_d.flag = wr_data[0];

        if (abort_req) begin
            q_d.st  = ST_RECOV;
            q_d.rec = '0;
            div_clr = 1'b1;
        end else if (start_req) begin
            q_d.st   = ST_CONV;
            q_d.idx  = IDX_W'(RES_W - 1);
            q_d.code = {1'b1, {(RES_W-1){1'b0}}};
            div_clr  = 1'b1;
        end else if (tick) begin
            unique case (q_q.st)
                ST_CONV: begin
                    if (!cmp_in) q_d.code[q_q.idx] = 1'b0;
                    if (q_q.idx == '0) begin
                        q_d.st = ST_LATCH;
                    end else begin
                        q_d.idx = idx_next;
                        q_d.code[idx_next] = 1'b1;
                    end
                end
                ST_LATCH: begin
                    latch_hit = 1'b1;
                    q_d.hi    = fmt_hi;
                    q_d.lo    = fmt_lo;
                    q_d.flag  = 1'b1;
                    q_d.st    = ST_IDLE;
                end
                ST_RECOV: begin
                    if (q_q.rec == REC_W'(REC_TICKS - 1)) q_d.st = ST_IDLE;
                    else q_d.rec = q_q.rec + REC_W'(1);
                end
                default: ;
            endcase
        end

        trial_code = q_q.code;
        res_hi     = q_q.hi;
        res_lo     = q_q.lo;
        done_flag  = q_q.flag;
        irq        = q_q.flag && q_q.ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q_q.en)); // R2
    AST_START_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (trial_code == {1'b1, {(RES_W-1){1'b0}}})); // R1
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_hi != $past(res_hi)) || (res_lo != $past(res_lo))) |-> $past(latch_hit)); // R7
    AST_RECOV_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_RECOV) |=> !busy); // R8
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done_flag || (q_q.st == ST_RECOV))); // R3
endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rc_tick = 1'b0;
    logic       cmp_in;
    logic [9:0] trial_code;
    logic       busy;
    logic [7:0] res_hi, res_lo;
    logic       done_flag, irq;
    logic [9:0] target = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign cmp_in = (target >= trial_code);

    sar_conv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rc_tick(rc_tick), .cmp_in(cmp_in),
        .trial_code(trial_code), .busy(busy), .res_hi(res_hi),
        .res_lo(res_lo), .done_flag(done_flag), .irq(irq)
    );

    typedef struct packed {
        logic [2:0] sel;
        logic       rj;
        logic       ie;
        logic [9:0] tgt;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [6:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'b000, 1'b0, 1'b1, 10'h3FF, 8'hFF, 8'hC0, 7'd2},
        '{3'b100, 1'b1, 1'b0, 10'h2A5, 8'h02, 8'hA5, 7'd4},
        '{3'b001, 1'b0, 1'b1, 10'h155, 8'h55, 8'h40, 7'd8},
        '{3'b101, 1'b1, 1'b1, 10'h000, 8'h00, 8'h00, 7'd16},
        '{3'b010, 1'b0, 1'b0, 10'h201, 8'h80, 8'h40, 7'd32},
        '{3'b110, 1'b1, 1'b1, 10'h37C, 8'h03, 8'h7C, 7'd64}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rc_pulse();
        @(negedge clk);
        rc_tick = 1'b1;
        @(negedge clk);
        rc_tick = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic ie, input logic rj,
                                       input logic go, input logic en);
        return {4'b0000, ie, rj, go, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got %0h expected %0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] prev_hi, prev_lo;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("reset busy", busy, 0);
        chk("reset hi/lo", {res_hi, res_lo}, 0);
        chk("reset flag/irq", {done_flag, irq}, 0);
        chk("reset trial", trial_code, 0);

        // R2: start in the same write that turns the converter on
        wr(0, ctl(0, 0, 1, 1));
        chk("R2 same-write start ignored", busy, 0);
        wr(0, 8'h00);
        wr(0, ctl(0, 0, 1, 0));
        chk("R2 start while off ignored", busy, 0);

        // vector table: R1 R3 R4 R5 R9 R10 R11
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            v = VECS[i];
            target = v.tgt;
            wr(2, 8'h00);
            wr(1, {5'b0, v.sel});
            wr(0, ctl(v.ie, v.rj, 0, 1));
            wr(0, ctl(v.ie, v.rj, 1, 1));
            chk("R1 busy after start", busy, 1);
            chk("R1 trial msb", trial_code, 10'h200);
            repeat (11 * int'(v.n) - 1) @(negedge clk);
            chk("R11 R4 busy before last period", busy, 1);
            @(negedge clk);
            chk("R3 R4 busy cleared", busy, 0);
            chk("R3 flag set", done_flag, 1);
            chk(v.rj ? "R10 hi" : "R9 hi", res_hi, v.hi);
            chk(v.rj ? "R10 lo" : "R9 lo", res_lo, v.lo);
            chk("R5 irq", irq, v.ie);
        end

        // R6: flag survives a new start, cleared by write
        target = 10'h0AA;
        wr(1, 8'h00);
        wr(0, ctl(1, 0, 1, 1));
        chk("R6 flag kept on start", done_flag, 1);
        repeat (24) @(negedge clk);
        chk("R6 second result hi", res_hi, 8'h2A);
        wr(2, 8'h00);
        chk("R6 flag cleared", done_flag, 0);
        chk("R5 irq follows flag", irq, 0);

        // R7: abort by clearing start bit
        prev_hi = res_hi; prev_lo = res_lo;
        target = 10'h123;
        wr(0, ctl(1, 0, 1, 1));
        repeat (7) @(negedge clk);
        wr(0, ctl(1, 0, 0, 1));
        chk("R7 busy drops on abort", busy, 0);
        repeat (30) @(negedge clk);
        chk("R7 result kept", {res_hi, res_lo}, {prev_hi, prev_lo});
        chk("R7 flag unchanged", done_flag, 0);

        // R8: recovery gap with ratio 4
        wr(1, 8'h04);
        target = 10'h1C7;
        wr(0, ctl(0, 1, 1, 1));
        repeat (5) @(negedge clk);
        wr(0, ctl(0, 1, 0, 1));
        wr(0, ctl(0, 1, 1, 1));
        chk("R8 start during recovery ignored", busy, 0);
        repeat (10) @(negedge clk);
        wr(0, ctl(0, 1, 1, 1));
        chk("R8 start after recovery", busy, 1);
        repeat (44) @(negedge clk);
        chk("R8 R10 hi after restart", res_hi, 8'h01);
        chk("R8 R10 lo after restart", res_lo, 8'hC7);

        // R7: abort by switching the converter off
        wr(1, 8'h00);
        wr(2, 8'h00);
        prev_hi = res_hi; prev_lo = res_lo;
        target = 10'h3F0;
        wr(0, ctl(0, 1, 1, 1));
        repeat (5) @(negedge clk);
        wr(0, 8'h00);
        chk("R7 off aborts", busy, 0);
        repeat (20) @(negedge clk);
        chk("R7 off keeps result", {res_hi, res_lo, 7'b0, done_flag},
            {prev_hi, prev_lo, 8'h00});

        // R4: external slow-clock enable
        wr(1, 8'h03);
        target = 10'h2F0;
        wr(0, ctl(0, 0, 0, 1));
        wr(0, ctl(0, 0, 1, 1));
        repeat (40) @(negedge clk);
        chk("R4 ext mode waits for rc_tick", busy, 1);
        for (int k = 0; k < 10; k++) rc_pulse();
        chk("R4 ext mode after ten ticks", busy, 1);
        rc_pulse();
        chk("R4 ext mode done", busy, 0);
        chk("R9 ext hi", res_hi, 8'hBC);
        chk("R9 ext lo", res_lo, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule